// File: doc/BRIEF.md
# Mode-Controlled Four-Bit Shift Register

A small storage register with one serial entry point, a parallel load path and a mode pin. Every action comes from one system clock. Two single-cycle strobes stand in for the two separate shift clocks of a discrete part.

With the mode pin low, the shift strobe moves the word one place toward the high end. The serial input fills the lowest bit. With the mode pin high, the load strobe copies the parallel inputs into all bits in one event. In each mode the strobe that belongs to the other mode does nothing.

A left shift is not built into the block. It comes from external wiring in parallel mode:
- each parallel input takes the output one place above it;
- the top parallel input takes the new serial bit.

Data entered this way moves from the high end toward the low end.

Top module: `dual_strobe_shreg`

## Requirements
- R1: A high synchronous reset `rst` at a clock edge sets all bits of `q_o` to 0.
- R2: With `mode_i` = 0 and `shift_stb_i` = 1 at an edge, the new `q_o` is the old `q_o[WIDTH-2:0]` with `ser_i` appended at bit 0. Bit i+1 takes old bit i. `load_stb_i` has no effect in that cycle.
- R3: With `mode_i` = 1 and `load_stb_i` = 1 at an edge, the new `q_o` equals `par_i` in full, in that single edge. `shift_stb_i` has no effect in that cycle.
- R4: With `mode_i` = 0, a `load_stb_i` pulse on its own leaves `q_o` unchanged.
- R5: With `mode_i` = 1, a `shift_stb_i` pulse on its own leaves `q_o` unchanged.
- R6: With neither strobe active, `q_o` holds its value.
- R7: After reset, WIDTH shift strobes in mode 0 load a complete serial word. Shifting in ones from zero gives 0001, 0011, 0111, 1111 (written MSB first).
- R8: In mode 1, the register acts as a left shift when `par_i[i]` is fed from `q_o[i+1]` and `par_i[WIDTH-1]` from the serial bit. Each load strobe then moves the data one place toward bit 0.
- R9: Every update appears on `q_o` right after the clock edge that samples its strobe, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = serial shift mode, 1 = parallel load mode |
| shift_stb_i | input | 1 | Single-cycle shift strobe, used in mode 0 |
| load_stb_i | input | 1 | Single-cycle load strobe, used in mode 1 |
| ser_i | input | 1 | Serial data entering bit 0 |
| par_i | input | WIDTH | Parallel load data |
| q_o | output | WIDTH | Register contents |

## Verification
Every result appears on `q_o` at the first rising edge after the cycle in which the strobe, reset or idle condition was driven, so no result is due later than one cycle.

The driver applies inputs at the falling edge. It pushes the expected word, taken from a reference model, into a queue at that moment. The monitor pops one entry one nanosecond after each rising edge and compares it. Each stimulus is therefore matched to exactly the edge that should have used it.

The ignored-strobe cases are checked the same way: the expected entry is simply the unchanged word. The left-shift case builds `par_i` from the observed `q_o` at each falling edge, as external wiring would.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   typedef enum logic {
      MODE_SERIAL   = 1'b0,
      MODE_PARALLEL = 1'b1
   } dsr_mode_e;

   typedef struct packed {
      logic shift_en;
      logic load_en;
   } dsr_ctrl_t;

endpackage

// File: rtl/dsr_strobe_qual.sv
module dsr_strobe_qual
   import dsr_pkg::*;
(
   input  logic      mode_i,
   input  logic      shift_stb_i,
   input  logic      load_stb_i,
   output dsr_ctrl_t ctrl_o
);

   dsr_mode_e mode;

   always_comb begin
      mode = dsr_mode_e'(mode_i);
      ctrl_o.shift_en = 1'b0;
      ctrl_o.load_en  = 1'b0;
      case (mode)
         MODE_SERIAL:   ctrl_o.shift_en = shift_stb_i;
         MODE_PARALLEL: ctrl_o.load_en  = load_stb_i;
         default: ;
      endcase
   end

endmodule

// File: rtl/dsr_stage.sv
module dsr_stage (
   input  logic clk,
   input  logic rst,
   input  logic shift_en,
   input  logic load_en,
   input  logic shift_in,
   input  logic load_in,
   output logic q
);

   logic nxt;

   always_comb begin
      nxt = q;
      if (load_en)       nxt = load_in;
      else if (shift_en) nxt = shift_in;
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= nxt;
   end

endmodule

// File: rtl/dual_strobe_shreg.sv
module dual_strobe_shreg
   import dsr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_i,
   input  logic             shift_stb_i,
   input  logic             load_stb_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dual_strobe_shreg: WIDTH must be at least 2");
      end
   endgenerate

   dsr_ctrl_t ctrl;

   dsr_strobe_qual u_qual (
      .mode_i      (mode_i),
      .shift_stb_i (shift_stb_i),
      .load_stb_i  (load_stb_i),
      .ctrl_o      (ctrl)
   );

   logic [MSB:0] shift_src;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign shift_src[i] = ser_i;
         end else begin : g_body
            assign shift_src[i] = q_o[i-1];
         end

         dsr_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .shift_en (ctrl.shift_en),
            .load_en  (ctrl.load_en),
            .shift_in (shift_src[i]),
            .load_in  (par_i[i]),
            .q        (q_o[i])
         );
      end
   endgenerate

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> q_o == '0);

   // R2
   serial_shift_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && shift_stb_i) |=> q_o == {$past(q_o[MSB-1:0]), $past(ser_i)});

   // R3
   parallel_load_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i && load_stb_i) |=> q_o == $past(par_i));

   // R4
   load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && !shift_stb_i) |=> $stable(q_o));

   // R5
   shift_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i && !load_stb_i) |=> $stable(q_o));

endmodule

// File: tb/test_dual_strobe_shreg.sv
module test_dual_strobe_shreg;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode_i = 1'b0;
   logic       shift_stb_i = 1'b0;
   logic       load_stb_i = 1'b0;
   logic       ser_i = 1'b0;
   logic [3:0] par_i = '0;
   logic [3:0] q_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [3:0] model = '0;
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   dual_strobe_shreg #(.WIDTH(4)) i_dual_strobe_shreg (
      .clk(clk), .rst(rst), .mode_i(mode_i), .shift_stb_i(shift_stb_i),
      .load_stb_i(load_stb_i), .ser_i(ser_i), .par_i(par_i), .q_o(q_o)
   );

   // Driver: apply inputs now and queue the word due after the next edge.
   task automatic drive(input logic r, input logic m, input logic sh,
                        input logic ld, input logic s, input logic [3:0] p,
                        input string tag);
      rst = r; mode_i = m; shift_stb_i = sh; load_stb_i = ld;
      ser_i = s; par_i = p;
      if (r)             model = '0;
      else if (!m && sh) model = {model[2:0], s};
      else if (m && ld)  model = p;
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   task automatic step(input logic r, input logic m, input logic sh,
                       input logic ld, input logic s, input logic [3:0] p,
                       input string tag);
      @(negedge clk);
      drive(r, m, sh, ld, s, p, tag);
   endtask

   // R8: external feedback wiring for the left shift
   task automatic lshift(input logic s);
      @(negedge clk);
      drive(1'b0, 1'b1, 1'b0, 1'b1, s, {s, q_o[3:1]}, "R8 left shift");
   endtask

   // Monitor (R9: each result is due just after the next rising edge)
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [3:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (q_o !== e) begin
            failures++;
            $display("FAIL %s (R9 timing): got %b expected %b", t, q_o, e);
         end
      end
   end

   initial begin
      step(1, 0, 0, 0, 0, 4'h0, "R1 reset");
      step(1, 0, 1, 1, 1, 4'hF, "R1 reset with strobes");
      // R7 and R2: shift ones in from zero
      step(0, 0, 1, 0, 1, 4'h0, "R7 shift 1");
      step(0, 0, 1, 0, 1, 4'h0, "R7 shift 2");
      step(0, 0, 1, 0, 1, 4'h0, "R7 shift 3");
      step(0, 0, 1, 0, 1, 4'h0, "R7 shift 4");
      step(0, 0, 0, 0, 0, 4'h3, "R6 idle hold");
      step(0, 1, 0, 0, 1, 4'h5, "R6 idle hold mode1");
      step(0, 0, 1, 0, 0, 4'h0, "R2 shift zero");
      step(0, 0, 1, 0, 1, 4'h0, "R2 shift one");
      step(0, 0, 0, 1, 0, 4'hA, "R4 load ignored");
      step(0, 1, 0, 1, 0, 4'h6, "R3 load");
      step(0, 1, 1, 0, 1, 4'h0, "R5 shift ignored");
      step(0, 1, 1, 1, 0, 4'h9, "R3 load with shift strobe");
      step(0, 0, 1, 1, 0, 4'hF, "R2 shift with load strobe");
      lshift(1'b1);
      lshift(1'b1);
      lshift(1'b0);
      lshift(1'b0);
      step(1, 1, 0, 1, 0, 4'hF, "R1 reset mid-run");
      // R7: serial word 1,0,1,1 after four strobes
      step(0, 0, 1, 0, 1, 4'h0, "R7 word bit 1");
      step(0, 0, 1, 0, 0, 4'h0, "R7 word bit 2");
      step(0, 0, 1, 0, 1, 4'h0, "R7 word bit 3");
      step(0, 0, 1, 0, 1, 4'h0, "R7 word bit 4");
      step(0, 0, 0, 0, 0, 4'h0, "R6 final hold");
      @(posedge clk);
      #2;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule